// File: doc/BRIEF.md
# Branch Resolution and Flush Controller

This block steers fetch and squashing around conditional branches in a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). A branch tests one register against zero. The instruction in decode presents its branch type, the register value, its PC and its immediate offset. The block returns four things: a next-PC select with the redirect address, a hold for the fetch PC, and a vector of flush strobes. Each strobe turns the word entering one pipeline register into a bubble.

Three policies are selectable. The first stalls until the branch is resolved in the memory stage. The second lets the fall-through instructions run and squashes them when the branch turns out taken. The third resolves the branch while it is still in decode, using a zero comparator and a target adder of its own. In that policy only the slot fetched behind a taken branch is lost.

The late policies need the branch's operand and target after it has left decode. A small shadow pipe keeps these alongside the real pipeline registers, and the shadow pipe obeys the same flushes. The resolution depth is a parameter. At its default the resolution point is the memory stage.

Top module: `br_flush_ctrl`

## Requirements
- R1: Branch type codes are 0 = none, 1 = branch if the register is zero, 2 = branch if the register is non-zero, 3 = none. A type-1 branch is taken exactly when the operand is zero, and a type-2 branch exactly when it is non-zero.
- R2: The redirect address is the branch PC plus 4, plus the sign-extended offset shifted left by two. Negative offsets give backward branches.
- R3: In stall mode every branch, taken or not, is followed in the retire stream by exactly three bubbles, then by the fall-through or the target instruction.
- R4: In stall mode the fetch PC is held while a branch sits in decode or execute, and also in memory when the branch is not taken. A taken branch redirects instead of holding in that last cycle, so the hold lasts 3 cycles per not-taken branch and 2 cycles per taken branch.
- R5: In predict-not-taken mode a not-taken branch costs no bubbles and the fetch PC is never held.
- R6: In predict-not-taken mode a taken branch is redirected when it reaches memory. The three younger instructions (in execute, decode and fetch) become bubbles, so exactly three bubbles follow it.
- R7: In early mode a taken branch is redirected from decode and only the slot fetched behind it is squashed, giving exactly one bubble.
- R8: In early mode a not-taken branch costs no bubbles and the fetch PC is never held.
- R9: Mode codes are 0 = stall, 1 = predict-not-taken, 2 = early resolve. Code 3 behaves exactly as stall mode.
- R10: During and right after reset, with no valid instruction in decode, the select, hold and all flush strobes are low.
- R11: In predict-not-taken mode, a branch squashed by an older taken branch has no effect on fetch, even if it would itself have been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Policy select (R9 encoding) |
| id_valid_i | input | 1 | Decode stage holds a valid instruction |
| id_br_type_i | input | 2 | Branch type of the decode instruction (R1 encoding) |
| id_rs_val_i | input | XLEN | Tested register value |
| id_pc_i | input | XLEN | PC of the decode instruction |
| id_imm_i | input | IMM_W | Branch offset in words, signed |
| pc_sel_o | output | 1 | Load the fetch PC from target_pc_o |
| target_pc_o | output | XLEN | Redirect address |
| pc_stall_o | output | 1 | Hold the fetch PC |
| flush_o | output | RES_DEPTH+1 | Bit 0 bubbles the fetch/decode register; bit k bubbles the register feeding stage k+1 |

## Verification
On every cycle, the assertions check the relations between the strobes. A redirect is never paired with a PC hold. Early mode squashes one register only. A taken branch in predict-not-taken mode squashes every younger stage. Stall mode never flushes beyond fetch/decode and keeps bubbling after a branch has left decode. A killed shadow entry is gone on the next cycle. Only the bench scenarios can show the whole-program behaviour: a small pipeline model drives the block and its retire stream is compared, slot by slot, against a trace derived from the mode rules. That covers bubble counts, the correct fall-through or target instruction, backward targets, branches squashed behind other branches, the count of PC-hold cycles and the reserved mode code.

// File: rtl/br_ctrl_pkg.sv
package br_ctrl_pkg;

  typedef enum logic [1:0] {
    MODE_STALL = 2'd0,
    MODE_PNT   = 2'd1,
    MODE_EARLY = 2'd2,
    MODE_RSVD  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    BR_NONE = 2'd0,
    BR_EQZ  = 2'd1,
    BR_NEZ  = 2'd2,
    BR_RSVD = 2'd3
  } br_e;

  // reserved code folds into stall
  function automatic mode_e norm_mode(input logic [1:0] m);
    case (m)
      2'd1:    return MODE_PNT;
      2'd2:    return MODE_EARLY;
      default: return MODE_STALL;
    endcase
  endfunction

  function automatic logic is_branch(input logic [1:0] t);
    return (t == BR_EQZ) || (t == BR_NEZ);
  endfunction

endpackage

// File: rtl/br_cond_unit.sv
module br_cond_unit
  import br_ctrl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]      typ_i,
  input  logic [XLEN-1:0] rs_i,
  output logic            taken_o
);
  logic is_zero;

  assign is_zero = (rs_i == '0);

  always_comb begin
    case (typ_i)
      BR_EQZ:  taken_o = is_zero;
      BR_NEZ:  taken_o = !is_zero;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/br_target_adder.sv
module br_target_adder #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  target_o
);
  localparam int EXT_W = XLEN - IMM_W - 2;

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] offset;

  assign seq_pc   = pc_i + XLEN'(4);
  assign offset   = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
  assign target_o = seq_pc + offset;
endmodule

// File: rtl/br_track_pipe.sv
// Shadow copy of in-flight branches, stage j tracks pipeline register j+1.
module br_track_pipe #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [1:0]       typ_i,
  input  logic [XLEN-1:0]  rs_i,
  input  logic [XLEN-1:0]  tgt_i,
  input  logic [DEPTH-1:0] kill_i,
  output logic             any_valid_o,
  output logic             res_valid_o,
  output logic [1:0]       res_typ_o,
  output logic [XLEN-1:0]  res_rs_o,
  output logic [XLEN-1:0]  res_tgt_o
);
  logic [DEPTH-1:0] v_q;
  logic [1:0]       ty_q [DEPTH];
  logic [XLEN-1:0]  rs_q [DEPTH];
  logic [XLEN-1:0]  tg_q [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_stage
    if (j == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[j]  <= 1'b0;
          ty_q[j] <= '0;
          rs_q[j] <= '0;
          tg_q[j] <= '0;
        end else begin
          v_q[j]  <= load_i && !kill_i[j];
          ty_q[j] <= typ_i;
          rs_q[j] <= rs_i;
          tg_q[j] <= tgt_i;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[j]  <= 1'b0;
          ty_q[j] <= '0;
          rs_q[j] <= '0;
          tg_q[j] <= '0;
        end else begin
          v_q[j]  <= v_q[j-1] && !kill_i[j];
          ty_q[j] <= ty_q[j-1];
          rs_q[j] <= rs_q[j-1];
          tg_q[j] <= tg_q[j-1];
        end
      end
    end

    // R6 R11: a squashed slot never carries a live branch
    p_kill_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      kill_i[j] |=> !v_q[j]);
  end

  assign any_valid_o = |v_q;
  assign res_valid_o = v_q[DEPTH-1];
  assign res_typ_o   = ty_q[DEPTH-1];
  assign res_rs_o    = rs_q[DEPTH-1];
  assign res_tgt_o   = tg_q[DEPTH-1];
endmodule

// File: rtl/br_flush_ctrl.sv
module br_flush_ctrl
  import br_ctrl_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int IMM_W     = 16,
  parameter int RES_DEPTH = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           mode_i,
  input  logic                 id_valid_i,
  input  logic [1:0]           id_br_type_i,
  input  logic [XLEN-1:0]      id_rs_val_i,
  input  logic [XLEN-1:0]      id_pc_i,
  input  logic [IMM_W-1:0]     id_imm_i,
  output logic                 pc_sel_o,
  output logic [XLEN-1:0]      target_pc_o,
  output logic                 pc_stall_o,
  output logic [RES_DEPTH:0]   flush_o
);
  localparam int FL_W = RES_DEPTH + 1;

  mode_e           mode_n;
  logic            late_mode;
  logic            id_br;
  logic            id_taken;
  logic [XLEN-1:0] id_tgt;
  logic            any_inflight;
  logic            res_valid;
  logic [1:0]      res_typ;
  logic [XLEN-1:0] res_rs;
  logic [XLEN-1:0] res_tgt;
  logic            res_cond;
  logic            res_taken;
  logic            busy;

  assign mode_n    = norm_mode(mode_i);
  assign late_mode = (mode_n != MODE_EARLY);
  assign id_br     = id_valid_i && is_branch(id_br_type_i);

  // decode-stage comparator and adder
  br_cond_unit #(.XLEN(XLEN)) i_id_cond (
    .typ_i   (id_br_type_i),
    .rs_i    (id_rs_val_i),
    .taken_o (id_taken)
  );

  br_target_adder #(.XLEN(XLEN), .IMM_W(IMM_W)) i_tgt_add (
    .pc_i     (id_pc_i),
    .imm_i    (id_imm_i),
    .target_o (id_tgt)
  );

  br_track_pipe #(.XLEN(XLEN), .DEPTH(RES_DEPTH)) i_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (id_br && late_mode),
    .typ_i       (id_br_type_i),
    .rs_i        (id_rs_val_i),
    .tgt_i       (id_tgt),
    .kill_i      (flush_o[RES_DEPTH:1]),
    .any_valid_o (any_inflight),
    .res_valid_o (res_valid),
    .res_typ_o   (res_typ),
    .res_rs_o    (res_rs),
    .res_tgt_o   (res_tgt)
  );

  // late resolution comparator
  br_cond_unit #(.XLEN(XLEN)) i_res_cond (
    .typ_i   (res_typ),
    .rs_i    (res_rs),
    .taken_o (res_cond)
  );

  assign res_taken = res_valid && res_cond;
  assign busy      = id_br || any_inflight;

  always_comb begin
    pc_sel_o    = 1'b0;
    pc_stall_o  = 1'b0;
    flush_o     = '0;
    target_pc_o = res_tgt;
    case (mode_n)
      MODE_EARLY: begin
        target_pc_o = id_tgt;
        if (id_br && id_taken) begin
          pc_sel_o   = 1'b1;
          flush_o[0] = 1'b1;
        end
      end
      MODE_PNT: begin
        if (res_taken) begin
          pc_sel_o = 1'b1;
          flush_o  = '1;
        end
      end
      default: begin
        if (busy) flush_o[0] = 1'b1;
        if (res_taken)  pc_sel_o   = 1'b1;
        else if (busy)  pc_stall_o = 1'b1;
      end
    endcase
  end

  // R4: redirect and hold never coincide
  p_sel_no_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_sel_o |-> !pc_stall_o);

  // R7: early redirect squashes only the fetch slot
  p_early_one_bubble_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_n == MODE_EARLY && pc_sel_o) |-> (flush_o == FL_W'(1)));

  // R6: late taken redirect squashes every younger stage
  p_pnt_squash_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_n == MODE_PNT && pc_sel_o) |-> (&flush_o));

  // R5 R8: speculative modes never hold fetch
  p_spec_no_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_n != MODE_STALL) |-> !pc_stall_o);

  // R3: stall mode only bubbles fetch/decode
  p_stall_shallow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_n == MODE_STALL) |-> (flush_o[RES_DEPTH:1] == '0));

  // R3: bubbling continues once the branch has left decode
  p_stall_keeps_bubbling_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_n == MODE_STALL && id_br) |=> (mode_n != MODE_STALL || flush_o[0]));
endmodule

// File: tb/test_br_flush_ctrl.sv
`timescale 1ns/1ps
module test_br_flush_ctrl;
  localparam int XLEN = 32, IMM_W = 16, RES_DEPTH = 2, PSZ = 32, WIN = 24;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;

  logic [1:0]      p_ty  [PSZ];
  logic [XLEN-1:0] p_rs  [PSZ];
  int              p_imm [PSZ];

  logic [XLEN-1:0] pc;
  logic ifid_v, idex_v, exmem_v, memwb_v;
  logic [4:0] ifid_i, idex_i, exmem_i, memwb_i;

  logic              pc_sel, pc_stall;
  logic [XLEN-1:0]   target;
  logic [RES_DEPTH:0] flush;

  int n_chk = 0, n_bad = 0, n_stall = 0, cyc = 0;
  int exp_s [WIN];
  int exp_st;

  br_flush_ctrl #(.XLEN(XLEN), .IMM_W(IMM_W), .RES_DEPTH(RES_DEPTH)) i_br_flush_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .mode_i       (mode),
    .id_valid_i   (ifid_v),
    .id_br_type_i (p_ty[ifid_i]),
    .id_rs_val_i  (p_rs[ifid_i]),
    .id_pc_i      ({25'd0, ifid_i, 2'b00}),
    .id_imm_i     (p_imm[ifid_i][IMM_W-1:0]),
    .pc_sel_o     (pc_sel),
    .target_pc_o  (target),
    .pc_stall_o   (pc_stall),
    .flush_o      (flush)
  );

  // minimal pipeline model driven by the controller
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
      {ifid_v, idex_v, exmem_v, memwb_v} <= '0;
      {ifid_i, idex_i, exmem_i, memwb_i} <= '0;
      n_stall <= 0;
    end else begin
      if (!pc_stall) pc <= pc_sel ? target : pc + 32'd4;
      ifid_v  <= !flush[0];
      ifid_i  <= pc[6:2];
      idex_v  <= ifid_v && !flush[1];
      idex_i  <= ifid_i;
      exmem_v <= idex_v && !flush[2];
      exmem_i <= idex_i;
      memwb_v <= exmem_v;
      memwb_i <= exmem_i;
      if (pc_stall) n_stall <= n_stall + 1;
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc > 50000);
    n_bad++;
    $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic clr_prog();
    for (int i = 0; i < PSZ; i++) begin
      p_ty[i] = 2'd0; p_rs[i] = '0; p_imm[i] = 0;
    end
  endtask

  task automatic set_br(input int idx, input logic [1:0] ty, input int rs, input int imm);
    p_ty[idx] = ty; p_rs[idx] = XLEN'(rs); p_imm[idx] = imm;
  endtask

  // retire-stream reference from the mode rules
  task automatic ref_model(input int md);
    int idx = 0, k = 0;
    bit tk, stall_like;
    int pen;
    exp_st = 0;
    stall_like = (md == 0) || (md == 3);
    while (k < WIN) begin
      exp_s[k] = idx; k++;
      if (p_ty[idx] == 2'd1 || p_ty[idx] == 2'd2) begin
        tk = (p_ty[idx] == 2'd1) ? (p_rs[idx] == 0) : (p_rs[idx] != 0);
        if (stall_like) begin pen = 3; exp_st += tk ? 2 : 3; end
        else if (md == 1) pen = tk ? 3 : 0;
        else pen = tk ? 1 : 0;
        for (int b = 0; b < pen && k < WIN; b++) begin exp_s[k] = -1; k++; end
        idx = tk ? ((idx + 1 + p_imm[idx]) & 31) : ((idx + 1) & 31);
      end else begin
        idx = (idx + 1) & 31;
      end
    end
  endtask

  task automatic run_case(input int md, input string tag);
    int guard = 0;
    int got;
    rst_n = 1'b0;
    mode  = 2'(md);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    ref_model(md);
    while (!memwb_v && guard < 100) begin @(negedge clk); guard++; end
    for (int k = 0; k < WIN; k++) begin
      got = memwb_v ? int'(memwb_i) : -1;
      chk(got == exp_s[k], $sformatf("%s slot %0d", tag, k), got, exp_s[k]);
      @(negedge clk);
    end
    chk(n_stall == exp_st, $sformatf("%s hold cycles", tag), n_stall, exp_st);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; mode = 2'd0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk({pc_sel, pc_stall, flush} == '0, "R10 in reset", int'({pc_sel, pc_stall, flush}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({pc_sel, pc_stall, flush} == '0, "R10 after reset", int'({pc_sel, pc_stall, flush}), 0);
  endtask

  task automatic t_stall_mix();
    clr_prog();
    set_br(2, 2'd1, 5, 0);   // R1 eqz not taken
    set_br(6, 2'd2, 7, 3);   // R1 nez taken -> 10
    run_case(0, "R3 R4 R1 stall");
  endtask

  task automatic t_stall_mix2();
    clr_prog();
    set_br(1, 2'd1, 0, 4);   // eqz taken -> 6
    set_br(8, 2'd2, 0, 9);   // nez not taken
    run_case(0, "R3 R4 R1 stall2");
  endtask

  task automatic t_pnt_not_taken();
    clr_prog();
    set_br(2, 2'd1, 9, 5);
    set_br(3, 2'd2, 0, 7);
    set_br(5, 2'd1, 1, 2);
    set_br(6, 2'd3, 0, 4);   // reserved type acts as no branch
    run_case(1, "R5 R1 pnt");
  endtask

  task automatic t_pnt_taken();
    clr_prog();
    set_br(3, 2'd1, 0, 5);   // -> 9
    run_case(1, "R6 pnt");
  endtask

  task automatic t_pnt_shadowed();
    clr_prog();
    set_br(3, 2'd2, 4, 8);   // -> 12
    set_br(4, 2'd1, 0, 10);  // squashed, would go to 15
    set_br(5, 2'd2, 1, 1);   // squashed
    run_case(1, "R11 R6 pnt");
  endtask

  task automatic t_early();
    clr_prog();
    set_br(2, 2'd1, 0, 3);   // -> 6
    set_br(6, 2'd2, 0, 4);   // not taken
    set_br(7, 2'd2, 4, -8);  // backward -> 0
    run_case(2, "R7 R8 R2 early");
  endtask

  task automatic t_mode3();
    clr_prog();
    set_br(2, 2'd1, 5, 0);
    set_br(6, 2'd2, 7, 3);
    run_case(3, "R9 mode3");
  endtask

  initial begin
    clr_prog();
    t_reset();
    t_stall_mix();
    t_stall_mix2();
    t_pnt_not_taken();
    t_pnt_taken();
    t_pnt_shadowed();
    t_early();
    t_mode3();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule